// File: doc/BRIEF.md
# TDM Timeslot Crossbar Switch

The block switches I/Q samples between several time-division ingress streams and several egress streams. Every stream carries frames of a fixed number of timeslots, one 32-bit sample (16-bit I, 16-bit Q) per slot and one slot per clock. All ingress ports are already aligned and share one frame-start strobe. A programmable map lets each egress timeslot take any slot of any ingress port. One ingress sample may feed any number of egress outputs.

Each ingress frame is copied into one double-banked sample memory per egress port. The egress side reads the frame completed one frame earlier while the current one is written. A per-egress map memory gives, slot by slot, the source port and the source slot. The map is loaded through a single-cycle write port into a shadow copy. A commit strobe makes that copy active at the next frame boundary.

Top module: `tdm_slot_switch`

## Requirements
- R1: While rst_ni is low and until the first full frame is buffered, every out_valid_o, out_sof_o and out_data_o bit is 0.
- R2: Egress port e, slot k, carries the sample that arrived on the mapped source port and source slot in the previous ingress frame. It appears N_SLOT+2 cycles after that sample entered, which is 2 cycles after ingress slot k of the following frame.
- R3: One source sample may be mapped to the same or different slots of several egress ports at once, up to all of them, and each receives the full sample.
- R4: The source slot of a map entry is independent of the egress slot index, so slots can be reordered (for example, reversed).
- R5: An egress slot whose active map entry has its valid bit clear outputs an all-zero sample, while out_valid_o stays high.
- R6: Map writes land in a shadow map and do not change the output. The shadow becomes active at the edge of the first frame_start_i cycle at or after a cfg_commit_i pulse, so a whole output frame always uses one map.
- R7: out_valid_o rises on the first egress slot of the second ingress frame after reset and stays high under periodic strobes. out_sof_o is high exactly on egress slot 0 of each output frame and only while valid.
- R8: frame_start_i restarts the ingress slot count at 0 even before a frame is complete. Egress slot timing restarts with it.
- R9: Map address = egress*N_SLOT + slot. cfg_data_i holds the source slot in bits [TW-1:0], the source port in bits [TW+PW-1:TW] and the valid bit in bit TW+PW (defaults TW=3, PW=2, so the valid bit is bit 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one timeslot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | High on ingress slot 0 of every port |
| in_data_i | input | N_IN*SW | Ingress samples, port p at bits [p*SW +: SW] |
| cfg_we_i | input | 1 | Shadow map write strobe |
| cfg_addr_i | input | AW | Map entry address (egress*N_SLOT+slot) |
| cfg_data_i | input | MW | Map entry {valid, source port, source slot} |
| cfg_commit_i | input | 1 | Arms the shadow-to-active copy at the next frame start |
| out_data_o | output | N_OUT*SW | Egress samples, port e at bits [e*SW +: SW] |
| out_valid_o | output | N_OUT | Egress sample valid |
| out_sof_o | output | N_OUT | Egress frame start, on output slot 0 |

## Verification
Two functions can fall in the same cycle here: a commit can coincide with a frame boundary, and shadow writes can coincide with the copy to the active map. Both are provoked by streaming random map loads and commits across frame edges without avoiding the strobe cycle, and by issuing an early frame strobe. The bench model applies the copy before the write in that cycle and judges every egress slot against the frame that was completed earlier. Slots that a shortened frame left unwritten are treated as don't-care.

// File: rtl/tdm_xbar_pkg.sv
package tdm_xbar_pkg;
  localparam int DEF_N_IN   = 4;
  localparam int DEF_N_OUT  = 4;
  localparam int DEF_N_SLOT = 8;
  localparam int DEF_SW     = 32;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_xbar_pkg::*;
#(
  parameter int N_SLOT = DEF_N_SLOT,
  localparam int TW = idx_w(N_SLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  output logic [TW-1:0] slot_o,
  output logic          bank_o,
  output logic          run_o,
  output logic          first_o
);
  logic [TW-1:0] slot_q;
  logic          bank_q, seen_q, run_q;

  // hold on last slot if a strobe is late
  assign slot_o  = sof_i ? '0 :
                   (slot_q == TW'(N_SLOT-1)) ? slot_q : slot_q + 1'b1;
  assign bank_o  = sof_i ? ~bank_q : bank_q;
  assign run_o   = sof_i ? seen_q : run_q;
  assign first_o = sof_i & seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= TW'(N_SLOT-1);
      bank_q <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      slot_q <= slot_o;
      bank_q <= bank_o;
      seen_q <= seen_q | sof_i;
      run_q  <= run_o;
    end
  end

  p_slot_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> slot_q == '0);
  p_slot_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= TW'(N_SLOT-1));
endmodule

// File: rtl/tdm_map_ram.sv
module tdm_map_ram
  import tdm_xbar_pkg::*;
#(
  parameter int N_IN   = DEF_N_IN,
  parameter int N_OUT  = DEF_N_OUT,
  parameter int N_SLOT = DEF_N_SLOT,
  localparam int PW    = idx_w(N_IN),
  localparam int TW    = idx_w(N_SLOT),
  localparam int MW    = 1 + PW + TW,
  localparam int DEPTH = N_OUT * N_SLOT,
  localparam int AW    = idx_w(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [MW-1:0]       data_i,
  input  logic                commit_i,
  input  logic [TW-1:0]       slot_i,
  output logic [N_OUT*MW-1:0] ent_o
);
  logic [DEPTH-1:0][MW-1:0] act_q, shd_q;
  logic pend_q, swap;

  assign swap = frame_start_i & (pend_q | commit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (we_i && (int'(addr_i) < DEPTH)) shd_q[addr_i] <= data_i;
      if (swap) act_q <= shd_q;
      pend_q <= (pend_q | commit_i) & ~swap;
    end
  end

  for (genvar e = 0; e < N_OUT; e++) begin : g_lookup
    assign ent_o[e*MW +: MW] = act_q[e*N_SLOT + int'(slot_i)];
  end

  p_swap_on_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_q));
  p_commit_consumed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && pend_q) |=> !pend_q);
endmodule

// File: rtl/tdm_egress_col.sv
module tdm_egress_col
  import tdm_xbar_pkg::*;
#(
  parameter int N_IN   = DEF_N_IN,
  parameter int N_SLOT = DEF_N_SLOT,
  parameter int SW     = DEF_SW,
  localparam int PW    = idx_w(N_IN),
  localparam int TW    = idx_w(N_SLOT),
  localparam int BD    = 2 * N_SLOT,
  localparam int BW    = idx_w(BD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IN*SW-1:0] wr_data_i,
  input  logic [TW-1:0]      wr_slot_i,
  input  logic               wr_bank_i,
  input  logic               ent_vld_i,
  input  logic [PW-1:0]      ent_port_i,
  input  logic [TW-1:0]      ent_slot_i,
  input  logic               run_i,
  input  logic               first_i,
  output logic [SW-1:0]      data_o,
  output logic               valid_o,
  output logic               sof_o
);
  logic [BW-1:0] wa, ra;
  logic [N_IN-1:0][SW-1:0] rd_q;
  logic [PW-1:0] sel_q;
  logic en_q, vld_q, sof_q;

  assign wa = BW'(int'(wr_bank_i) * N_SLOT + int'(wr_slot_i));
  assign ra = BW'(int'(~wr_bank_i) * N_SLOT + int'(ent_slot_i));

  // one memory per ingress row; every row holds its full frame
  for (genvar i = 0; i < N_IN; i++) begin : g_row
    logic [SW-1:0] mem [BD];
    always_ff @(posedge clk_i) begin
      mem[wa] <= wr_data_i[i*SW +: SW];
      rd_q[i] <= mem[ra];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      vld_q <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      sel_q <= ent_port_i;
      en_q  <= ent_vld_i & run_i;
      vld_q <= run_i;
      sof_q <= first_i;
    end
  end

  assign data_o  = en_q ? rd_q[sel_q] : '0;
  assign valid_o = vld_q;
  assign sof_o   = sof_q;

  p_sof_only_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o);
  p_valid_rise_on_sof_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> sof_o);
endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch
  import tdm_xbar_pkg::*;
#(
  parameter int N_IN   = DEF_N_IN,
  parameter int N_OUT  = DEF_N_OUT,
  parameter int N_SLOT = DEF_N_SLOT,
  parameter int SW     = DEF_SW,
  localparam int PW    = idx_w(N_IN),
  localparam int TW    = idx_w(N_SLOT),
  localparam int MW    = 1 + PW + TW,
  localparam int AW    = idx_w(N_OUT * N_SLOT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic [N_IN*SW-1:0]  in_data_i,
  input  logic                cfg_we_i,
  input  logic [AW-1:0]       cfg_addr_i,
  input  logic [MW-1:0]       cfg_data_i,
  input  logic                cfg_commit_i,
  output logic [N_OUT*SW-1:0] out_data_o,
  output logic [N_OUT-1:0]    out_valid_o,
  output logic [N_OUT-1:0]    out_sof_o
);
  logic [N_IN*SW-1:0]  in_q;
  logic                sof_q;
  logic [TW-1:0]       slot;
  logic                bank, run, first;
  logic [N_OUT*MW-1:0] ent;

  // input stage lets the map swap settle before slot 0 is looked up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      sof_q <= 1'b0;
    end else begin
      in_q  <= in_data_i;
      sof_q <= frame_start_i;
    end
  end

  tdm_slot_ctrl #(.N_SLOT(N_SLOT)) u_ctrl (
    .clk_i, .rst_ni, .sof_i(sof_q),
    .slot_o(slot), .bank_o(bank), .run_o(run), .first_o(first)
  );

  tdm_map_ram #(.N_IN(N_IN), .N_OUT(N_OUT), .N_SLOT(N_SLOT)) u_map (
    .clk_i, .rst_ni, .frame_start_i,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .commit_i(cfg_commit_i), .slot_i(slot), .ent_o(ent)
  );

  for (genvar e = 0; e < N_OUT; e++) begin : g_col
    logic [MW-1:0] me;
    assign me = ent[e*MW +: MW];
    tdm_egress_col #(.N_IN(N_IN), .N_SLOT(N_SLOT), .SW(SW)) u_col (
      .clk_i, .rst_ni,
      .wr_data_i(in_q), .wr_slot_i(slot), .wr_bank_i(bank),
      .ent_vld_i(me[MW-1]), .ent_port_i(me[TW +: PW]), .ent_slot_i(me[TW-1:0]),
      .run_i(run), .first_i(first),
      .data_o(out_data_o[e*SW +: SW]), .valid_o(out_valid_o[e]), .sof_o(out_sof_o[e])
    );
  end

  p_ports_in_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o == '0) || (out_valid_o == '1));
endmodule

// File: tb/sim_tdm_slot_switch.sv
module sim_tdm_slot_switch;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 4, N_OUT = 4, N_SLOT = 8, SW = 32;
  localparam int PW = 2, TW = 3, MW = 1 + PW + TW, AW = 5;

  logic clk = 1'b0, rst_ni = 1'b0, frame_start_i = 1'b0;
  logic [N_IN*SW-1:0]  in_data_i = '0;
  logic cfg_we_i = 1'b0, cfg_commit_i = 1'b0;
  logic [AW-1:0] cfg_addr_i = '0;
  logic [MW-1:0] cfg_data_i = '0;
  logic [N_OUT*SW-1:0] out_data_o;
  logic [N_OUT-1:0] out_valid_o, out_sof_o;

  tdm_slot_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .N_SLOT(N_SLOT), .SW(SW)) u0 (.*, .clk_i(clk));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase_tag = "R2";

  // bench model
  logic [SW-1:0] cur [N_IN][N_SLOT];
  logic [SW-1:0] prv [N_IN][N_SLOT];
  bit cur_w [N_SLOT], prv_w [N_SLOT];
  int act_v [N_OUT][N_SLOT], act_p [N_OUT][N_SLOT], act_s [N_OUT][N_SLOT];
  int shd_v [N_OUT][N_SLOT], shd_p [N_OUT][N_SLOT], shd_s [N_OUT][N_SLOT];
  bit pend = 0;
  int bslot = -1, flen = N_SLOT, fidx = -1, cyc = 0;
  logic [SW-1:0] x_d [4][N_OUT];
  bit x_v [4][N_OUT], x_s [4][N_OUT], x_dc [4][N_OUT];
  string x_t [4][N_OUT];

  task automatic chk(string tag, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [MW-1:0] cfg_word(int v, int p, int s);
    return {v[0], p[PW-1:0], s[TW-1:0]};  // R9 field layout
  endfunction

  task automatic tick(bit we = 0, int e = 0, int k = 0, int v = 0, int p = 0, int s = 0,
                      bit com = 0);
    int nx, r;
    bit fs;
    @(negedge clk);
    r = cyc % 4;
    for (int o = 0; o < N_OUT; o++) begin
      chk("R7", SW'(out_valid_o[o]), SW'(x_v[r][o]));
      chk("R7", SW'(out_sof_o[o]), SW'(x_s[r][o]));
      if (!x_dc[r][o]) chk(x_t[r][o], out_data_o[o*SW +: SW], x_d[r][o]);
    end
    nx = (bslot < 0 || bslot >= flen - 1) ? 0 : bslot + 1;
    fs = (nx == 0);
    if (fs) begin
      if (pend || com) begin
        act_v = shd_v; act_p = shd_p; act_s = shd_s;
        pend = 0;
      end
      fidx++;
      prv = cur; prv_w = cur_w;
      foreach (cur_w[i]) cur_w[i] = 0;
    end else if (com) pend = 1;
    if (we) begin
      shd_v[e][k] = v; shd_p[e][k] = p; shd_s[e][k] = s;
    end
    frame_start_i = fs;
    cfg_we_i = we;
    cfg_addr_i = AW'(e * N_SLOT + k);
    cfg_data_i = cfg_word(v, p, s);
    cfg_commit_i = com;
    for (int i = 0; i < N_IN; i++) begin
      cur[i][nx] = $urandom;
      in_data_i[i*SW +: SW] = cur[i][nx];
    end
    cur_w[nx] = 1;
    r = (cyc + 2) % 4;
    for (int o = 0; o < N_OUT; o++) begin
      x_v[r][o] = (fidx >= 1);
      x_s[r][o] = (fidx >= 1) && fs;
      x_dc[r][o] = 0;
      x_t[r][o] = phase_tag;
      if (fidx < 1) begin
        x_d[r][o] = '0; x_t[r][o] = "R1";
      end else if (!act_v[o][nx]) begin
        x_d[r][o] = '0; x_t[r][o] = "R5";
      end else begin
        x_d[r][o] = prv[act_p[o][nx]][act_s[o][nx]];
        x_dc[r][o] = !prv_w[act_s[o][nx]];
      end
    end
    bslot = nx;
    cyc++;
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n * N_SLOT; i++) tick();
  endtask

  // mode 0 random, 1 broadcast, 2 reversal, 3 half invalid, 4 single top entry
  task automatic load_map(int mode, bit com);
    for (int e = 0; e < N_OUT; e++)
      for (int k = 0; k < N_SLOT; k++) begin
        int v = 1, p = $urandom % N_IN, s = $urandom % N_SLOT;
        if (mode == 1) begin p = 2; s = k; end
        if (mode == 2) begin p = e; s = N_SLOT - 1 - k; end
        if (mode == 3) v = $urandom % 2;
        if (mode == 4) begin
          v = (e == N_OUT-1 && k == N_SLOT-1); p = 1; s = 0;
        end
        tick(1, e, k, v, p, s);
      end
    if (com) tick(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    foreach (act_v[e, k]) begin
      act_v[e][k] = 0; act_p[e][k] = 0; act_s[e][k] = 0;
      shd_v[e][k] = 0; shd_p[e][k] = 0; shd_s[e][k] = 0;
    end
    foreach (cur_w[i]) begin cur_w[i] = 0; prv_w[i] = 0; end
    foreach (x_v[r, o]) begin
      x_v[r][o] = 0; x_s[r][o] = 0; x_dc[r][o] = 0; x_d[r][o] = '0; x_t[r][o] = "R1";
    end
    repeat (3) @(negedge clk);
    chk("R1", SW'(out_valid_o), '0);
    chk("R1", SW'(out_sof_o), '0);
    chk("R1", out_data_o[SW-1:0], '0);
    rst_ni = 1'b1;
    phase_tag = "R2"; load_map(0, 1); frames(4);
    phase_tag = "R3"; load_map(1, 1); frames(3);
    phase_tag = "R4"; load_map(2, 1); frames(3);
    phase_tag = "R5"; load_map(3, 1); frames(3);
    phase_tag = "R6"; load_map(0, 0); frames(3);
    tick(0, 0, 0, 0, 0, 0, 1); frames(2);
    phase_tag = "R8"; flen = 5; for (int i = 0; i < 5; i++) tick();
    flen = N_SLOT; frames(3);
    phase_tag = "R9"; load_map(4, 1); frames(2);
    phase_tag = "R2";
    for (int n = 0; n < 6; n++) begin load_map(0, 1); frames(2); end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule